// File: doc/BRIEF.md
# Rendezvous Word Synchronization Unit

This block pairs a producer thread with a consumer thread through a shared memory word. Each word in a small internal store has an ownership flag kept apart from its 64-bit data. A producer issues a rendezvous-store with its thread ID, a word address and a value. A consumer issues a rendezvous-load with its thread ID and the same address. Whichever side arrives first parks on the word. It records its thread ID as owner and receives a suspend response. The side that arrives second completes the exchange, receives a done response, and causes a one-cycle wake event that names the parked thread.

The store is a rendezvous point and not a plain memory. A word that has completed an exchange becomes free again, and the next request of either kind to it starts a new rendezvous. A second request of the same kind to a word that already has a parked thread is refused with an error response and leaves the word untouched. Requests arrive one per cycle on a valid/ready handshake. The response and any wake event appear together on the cycle after acceptance.

Top module: `rdv_sync_unit`

## Requirements
- R1: While reset is asserted, req_ready, rsp_valid and wake_valid are 0 and every word is made free. req_ready is 1 from the first clock edge after reset is released.
- R2: Each accepted request (req_valid and req_ready both 1 at a clock edge) gives exactly one response with rsp_valid = 1 on the next cycle, and rsp_tid repeats the requester's req_tid. A cycle with no accepted request gives rsp_valid = 0 on the next cycle.
- R3: A rendezvous-store (req_op = 0) to a free word returns rsp_status = 1 (suspend) with rsp_rdata = 0 and no wake. The word then holds the value and is owned by the storing thread.
- R4: A rendezvous-load (req_op = 1) to a word owned by a producer returns rsp_status = 0 (done) with rsp_rdata equal to the deposited value. In the same cycle it asserts wake_valid for one cycle with wake_tid equal to the producer's ID.
- R5: A rendezvous-load to a free word returns rsp_status = 1 (suspend) with rsp_rdata = 0 and no wake. The word then becomes owned by the loading thread.
- R6: A rendezvous-store to a word owned by a consumer returns rsp_status = 0 (done) with rsp_rdata equal to the stored value. In the same cycle it asserts wake_valid with wake_tid equal to the consumer's ID.
- R7: A request of the same kind as the current owner's returns rsp_status = 2 (error) with rsp_rdata = 0 and no wake. The word's owner, owner kind and data are unchanged.
- R8: After an exchange completes, the word is free. The next request of either kind to it suspends.
- R9: Words are independent. Requests to one address never change the state of another, including the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 1 | 0 = rendezvous-store, 1 = rendezvous-load |
| req_tid | input | 8 | Requesting thread ID |
| req_addr | input | 4 | Word address |
| req_wdata | input | 64 | Value offered by a store |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 done, 1 suspend, 2 error |
| rsp_tid | output | 8 | Thread the response belongs to |
| rsp_rdata | output | 64 | Exchanged value on done, otherwise 0 |
| wake_valid | output | 1 | One-cycle wake event |
| wake_tid | output | 8 | Thread to resume |

## Verification
The hardest effect to reach is the lack of change after a refused duplicate. Nothing at the ports shows the word's owner or data directly. The stimulus therefore parks a thread, sends a same-kind request from a second thread, and then completes the exchange from the opposite side. The wake ID and returned data must still name the first thread and its value. The same approach shows that a word is free again after an exchange and that a reset in the middle of a run frees a parked word.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

  // Who, if anyone, is parked on a word
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PROD = 2'd1,
    SLOT_CONS = 2'd2
  } slot_e;

  typedef enum logic [1:0] {
    RSP_DONE    = 2'd0,
    RSP_SUSPEND = 2'd1,
    RSP_ERROR   = 2'd2
  } rsp_e;

  // Source of the data returned in the response
  typedef enum logic [1:0] {
    RD_ZERO     = 2'd0,
    RD_STORED   = 2'd1,
    RD_INCOMING = 2'd2
  } rdsel_e;

  localparam logic OP_STORE = 1'b0;
  localparam logic OP_LOAD  = 1'b1;

  typedef struct packed {
    slot_e  next_slot;
    logic   set_owner;
    logic   put_data;
    logic   wake;
    logic   park;
    logic   reject;
    rdsel_e rd_sel;
    rsp_e   status;
  } verdict_t;

  // Outcome of one request given the word's current occupant
  function automatic verdict_t judge(input logic op, input slot_e cur);
    verdict_t v;
    v.next_slot = cur;
    v.set_owner = 1'b0;
    v.put_data  = 1'b0;
    v.wake      = 1'b0;
    v.park      = 1'b0;
    v.reject    = 1'b0;
    v.rd_sel    = RD_ZERO;
    v.status    = RSP_ERROR;
    case (cur)
      SLOT_FREE: begin
        v.park      = 1'b1;
        v.set_owner = 1'b1;
        v.put_data  = (op == OP_STORE);
        v.next_slot = (op == OP_STORE) ? SLOT_PROD : SLOT_CONS;
        v.status    = RSP_SUSPEND;
      end
      SLOT_PROD: begin
        if (op == OP_LOAD) begin
          v.next_slot = SLOT_FREE;
          v.wake      = 1'b1;
          v.rd_sel    = RD_STORED;
          v.status    = RSP_DONE;
        end else begin
          v.reject = 1'b1;
        end
      end
      SLOT_CONS: begin
        if (op == OP_STORE) begin
          v.next_slot = SLOT_FREE;
          v.put_data  = 1'b1;
          v.wake      = 1'b1;
          v.rd_sel    = RD_INCOMING;
          v.status    = RSP_DONE;
        end else begin
          v.reject = 1'b1;
        end
      end
      default: v.reject = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rdv_word_bank.sv
module rdv_word_bank #(
  parameter int NUM_WORDS = 16,
  parameter int DATA_W    = 64,
  parameter int TID_W     = 8,
  parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     rd_addr,
  output rdv_pkg::slot_e        rd_slot,
  output logic [TID_W-1:0]      rd_owner,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  rdv_pkg::slot_e        wr_slot,
  input  logic                  wr_owner_en,
  input  logic [TID_W-1:0]      wr_owner,
  input  logic                  wr_data_en,
  input  logic [DATA_W-1:0]     wr_data
);
  import rdv_pkg::*;

  slot_e             slot_arr  [NUM_WORDS];
  logic [TID_W-1:0]  owner_arr [NUM_WORDS];
  logic [DATA_W-1:0] data_arr  [NUM_WORDS];

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(gi));

    // Ownership state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_arr[gi]  <= SLOT_FREE;
        owner_arr[gi] <= '0;
      end else if (hit) begin
        slot_arr[gi] <= wr_slot;
        if (wr_owner_en) owner_arr[gi] <= wr_owner;
      end
    end

    // Data kept apart so a deposited value survives until taken
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 data_arr[gi] <= '0;
      else if (hit && wr_data_en) data_arr[gi] <= wr_data;
    end
  end

  assign rd_slot  = slot_arr[rd_addr];
  assign rd_owner = owner_arr[rd_addr];
  assign rd_data  = data_arr[rd_addr];

endmodule

// File: rtl/rdv_resolver.sv
module rdv_resolver #(
  parameter int DATA_W = 64,
  parameter int TID_W  = 8
) (
  input  logic               op,
  input  logic [DATA_W-1:0]  wdata,
  input  rdv_pkg::slot_e     cur_slot,
  input  logic [TID_W-1:0]   cur_owner,
  input  logic [DATA_W-1:0]  cur_data,
  output rdv_pkg::slot_e     next_slot,
  output logic               set_owner,
  output logic               put_data,
  output logic               park,
  output logic               match,
  output logic               reject,
  output logic [TID_W-1:0]   wake_tid,
  output logic [DATA_W-1:0]  rdata,
  output logic [1:0]         status
);
  import rdv_pkg::*;

  verdict_t v;

  always_comb begin
    v = judge(op, cur_slot);
  end

  assign next_slot = v.next_slot;
  assign set_owner = v.set_owner;
  assign put_data  = v.put_data;
  assign park      = v.park;
  assign match     = v.wake;
  assign reject    = v.reject;
  assign wake_tid  = cur_owner;
  assign status    = v.status;

  always_comb begin
    case (v.rd_sel)
      RD_STORED:   rdata = cur_data;
      RD_INCOMING: rdata = wdata;
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/rdv_resp_stage.sv
module rdv_resp_stage #(
  parameter int DATA_W = 64,
  parameter int TID_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               wake_in,
  input  logic [1:0]         status_in,
  input  logic [TID_W-1:0]   tid_in,
  input  logic [TID_W-1:0]   wake_tid_in,
  input  logic [DATA_W-1:0]  rdata_in,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [TID_W-1:0]   rsp_tid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               wake_valid,
  output logic [TID_W-1:0]   wake_tid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_tid    <= '0;
      rsp_rdata  <= '0;
      wake_valid <= 1'b0;
      wake_tid   <= '0;
    end else begin
      rsp_valid  <= fire;
      wake_valid <= fire && wake_in;
      if (fire) begin
        rsp_status <= status_in;
        rsp_tid    <= tid_in;
        rsp_rdata  <= rdata_in;
        wake_tid   <= wake_in ? wake_tid_in : '0;
      end
    end
  end

endmodule

// File: rtl/rdv_sync_unit.sv
module rdv_sync_unit #(
  parameter int NUM_WORDS = 16,
  parameter int DATA_W    = 64,
  parameter int TID_W     = 8,
  localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_op,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [TID_W-1:0]   rsp_tid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               wake_valid,
  output logic [TID_W-1:0]   wake_tid
);
  import rdv_pkg::*;

  logic              ready_q;
  slot_e             cur_slot;
  slot_e             next_slot;
  logic [TID_W-1:0]  cur_owner;
  logic [DATA_W-1:0] cur_data;
  logic              set_owner;
  logic              put_data;
  logic              park;
  logic              match;
  logic              reject;
  logic [TID_W-1:0]  pend_wake_tid;
  logic [DATA_W-1:0] pend_rdata;
  logic [1:0]        pend_status;

  // Named internal events, observed by the bound checker
  logic ev_accept;
  logic ev_park;
  logic ev_match;
  logic ev_reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign ev_accept = req_valid && ready_q;
  assign ev_park   = ev_accept && park;
  assign ev_match  = ev_accept && match;
  assign ev_reject = ev_accept && reject;

  rdv_word_bank #(
    .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .TID_W(TID_W), .ADDR_W(ADDR_W)
  ) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_addr     (req_addr),
    .rd_slot     (cur_slot),
    .rd_owner    (cur_owner),
    .rd_data     (cur_data),
    .wr_en       (ev_accept && !reject),
    .wr_addr     (req_addr),
    .wr_slot     (next_slot),
    .wr_owner_en (set_owner),
    .wr_owner    (req_tid),
    .wr_data_en  (put_data),
    .wr_data     (req_wdata)
  );

  rdv_resolver #(.DATA_W(DATA_W), .TID_W(TID_W)) resolve_i (
    .op        (req_op),
    .wdata     (req_wdata),
    .cur_slot  (cur_slot),
    .cur_owner (cur_owner),
    .cur_data  (cur_data),
    .next_slot (next_slot),
    .set_owner (set_owner),
    .put_data  (put_data),
    .park      (park),
    .match     (match),
    .reject    (reject),
    .wake_tid  (pend_wake_tid),
    .rdata     (pend_rdata),
    .status    (pend_status)
  );

  rdv_resp_stage #(.DATA_W(DATA_W), .TID_W(TID_W)) resp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (ev_accept),
    .wake_in     (match),
    .status_in   (pend_status),
    .tid_in      (req_tid),
    .wake_tid_in (pend_wake_tid),
    .rdata_in    (pend_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_tid     (rsp_tid),
    .rsp_rdata   (rsp_rdata),
    .wake_valid  (wake_valid),
    .wake_tid    (wake_tid)
  );

endmodule

// File: rtl/rdv_sync_unit_chk.sv
module rdv_sync_unit_chk #(
  parameter int DATA_W = 64,
  parameter int TID_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_op,
  input logic [TID_W-1:0]  req_tid,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [TID_W-1:0]  rsp_tid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              wake_valid,
  input logic              ev_accept,
  input logic              ev_park,
  input logic              ev_match,
  input logic              ev_reject
);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) ev_accept |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ev_accept |=> !rsp_valid); // R2
  AST_TID_ECHO: assert property (@(posedge clk) disable iff (!rst_n) ev_accept |=> rsp_tid == $past(req_tid)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ev_park, ev_match, ev_reject})); // R2
  AST_PARK_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n) ev_park |=> (rsp_status == 2'd1 && !wake_valid && rsp_rdata == '0)); // R3
  AST_MATCH_WAKES: assert property (@(posedge clk) disable iff (!rst_n) ev_match |=> (wake_valid && rsp_status == 2'd0)); // R4
  AST_STORE_ECHO: assert property (@(posedge clk) disable iff (!rst_n) (ev_match && req_op == 1'b0) |=> rsp_rdata == $past(req_wdata)); // R6
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ev_reject |=> (rsp_status == 2'd2 && !wake_valid && rsp_rdata == '0)); // R7
  AST_WAKE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n) wake_valid |-> (rsp_valid && rsp_status == 2'd0)); // R4

endmodule

bind rdv_sync_unit rdv_sync_unit_chk #(.DATA_W(DATA_W), .TID_W(TID_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_op     (req_op),
  .req_tid    (req_tid),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_tid    (rsp_tid),
  .rsp_rdata  (rsp_rdata),
  .wake_valid (wake_valid),
  .ev_accept  (ev_accept),
  .ev_park    (ev_park),
  .ev_match   (ev_match),
  .ev_reject  (ev_reject)
);

// File: tb/rdv_sync_unit_tb_top.sv
module rdv_sync_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [7:0]  req_tid = '0;
  logic [3:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [7:0]  rsp_tid;
  logic [63:0] rsp_rdata;
  logic        wake_valid;
  logic [7:0]  wake_tid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  rdv_sync_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_tid(req_tid), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_tid(rsp_tid),
    .rsp_rdata(rsp_rdata), .wake_valid(wake_valid), .wake_tid(wake_tid)
  );

  // op | tid | addr | wdata | status | rdata | wake | wake tid
  localparam int NV = 16;
  localparam logic [151:0] VEC [NV] = '{
    {1'b0, 8'h11, 4'd0,  64'h00000000000000A5, 2'd1, 64'h0, 1'b0, 8'h00},                 // R3
    {1'b1, 8'h22, 4'd0,  64'h0, 2'd0, 64'h00000000000000A5, 1'b1, 8'h11},                 // R4
    {1'b1, 8'h33, 4'd1,  64'h0, 2'd1, 64'h0, 1'b0, 8'h00},                                // R5
    {1'b0, 8'h44, 4'd1,  64'h12345678000000B6, 2'd0, 64'h12345678000000B6, 1'b1, 8'h33},  // R6
    {1'b0, 8'h55, 4'd2,  64'h00000000000000C1, 2'd1, 64'h0, 1'b0, 8'h00},                 // R3
    {1'b0, 8'h66, 4'd2,  64'h00000000000000C2, 2'd2, 64'h0, 1'b0, 8'h00},                 // R7
    {1'b1, 8'h77, 4'd2,  64'h0, 2'd0, 64'h00000000000000C1, 1'b1, 8'h55},                 // R7
    {1'b1, 8'h12, 4'd3,  64'h0, 2'd1, 64'h0, 1'b0, 8'h00},                                // R5
    {1'b1, 8'h13, 4'd3,  64'h0, 2'd2, 64'h0, 1'b0, 8'h00},                                // R7
    {1'b0, 8'h14, 4'd3,  64'h00000000000000D4, 2'd0, 64'h00000000000000D4, 1'b1, 8'h12},  // R7
    {1'b1, 8'h15, 4'd0,  64'h0, 2'd1, 64'h0, 1'b0, 8'h00},                                // R8
    {1'b0, 8'h16, 4'd0,  64'h00000000000000E5, 2'd0, 64'h00000000000000E5, 1'b1, 8'h15},  // R8
    {1'b0, 8'hFF, 4'd15, 64'hFFFFFFFFFFFFFFFF, 2'd1, 64'h0, 1'b0, 8'h00},                 // R9
    {1'b0, 8'h01, 4'd14, 64'h0000000000000001, 2'd1, 64'h0, 1'b0, 8'h00},                 // R9
    {1'b1, 8'h02, 4'd15, 64'h0, 2'd0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 8'hFF},                 // R9
    {1'b1, 8'h03, 4'd14, 64'h0, 2'd0, 64'h0000000000000001, 1'b1, 8'h01}                  // R9
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // Called at a falling edge; drives one request and checks its response a cycle later
  task automatic do_req(input logic op, input logic [7:0] tid, input logic [3:0] addr,
                        input logic [63:0] wd, input logic [1:0] est, input logic [63:0] erd,
                        input logic ewk, input logic [7:0] ewt, input string tag);
    req_valid = 1'b1; req_op = op; req_tid = tid; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_tid == tid, {tag, " R2 rsp_tid"}, 64'(rsp_tid), 64'(tid));
    check(rsp_status == est, {tag, " status"}, 64'(rsp_status), 64'(est));
    check(rsp_rdata == erd, {tag, " rdata"}, rsp_rdata, erd);
    check(wake_valid == ewk, {tag, " wake_valid"}, 64'(wake_valid), 64'(ewk));
    if (ewk) check(wake_tid == ewt, {tag, " wake_tid"}, 64'(wake_tid), 64'(ewt));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R1 ready in reset", 64'(req_ready), 64'd0);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check(wake_valid == 1'b0, "R1 wake_valid in reset", 64'(wake_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after release", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      logic [151:0] v;
      v = VEC[i];
      do_req(v[151], v[150:143], v[142:139], v[138:75], v[74:73], v[72:9], v[8], v[7:0],
             $sformatf("vec%0d", i));
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 idle no response", 64'(rsp_valid), 64'd0);
    check(wake_valid == 1'b0, "R2 idle no wake", 64'(wake_valid), 64'd0);

    // R1: reset in mid-run frees a parked word
    do_req(1'b0, 8'h90, 4'd5, 64'hCAFE, 2'd1, 64'h0, 1'b0, 8'h00, "R1 park before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp cleared by reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(1'b1, 8'h91, 4'd5, 64'h0, 2'd1, 64'h0, 1'b0, 8'h00, "R1 word free after reset");

    // R7: repeated refusals leave the consumer parked; back-to-back requests
    do_req(1'b1, 8'h92, 4'd5, 64'h0, 2'd2, 64'h0, 1'b0, 8'h00, "R7 dup load a");
    do_req(1'b1, 8'h93, 4'd5, 64'h0, 2'd2, 64'h0, 1'b0, 8'h00, "R7 dup load b");
    do_req(1'b0, 8'h94, 4'd5, 64'h5A5A5A5A5A5A5A5A, 2'd0, 64'h5A5A5A5A5A5A5A5A, 1'b1, 8'h91,
           "R6 store wakes first consumer");
    // R8: freed word parks a producer again
    do_req(1'b0, 8'h95, 4'd5, 64'h7, 2'd1, 64'h0, 1'b0, 8'h00, "R8 new rendezvous");
    do_req(1'b1, 8'h96, 4'd5, 64'h0, 2'd0, 64'h7, 1'b1, 8'h95, "R4 second exchange");

    finish_run();
  end

endmodule